// File: doc/BRIEF.md
# Two-Wire Master Register Interface

This block is the software-facing half of a two-wire (I2C-style) master controller. A simple host bus reads and writes 32-bit words at word-aligned byte offsets. The block holds the two bus-clock settings, the configuration word, the target address, the command word and an eight-byte data buffer, and it presents all of them as steady outputs to a separate transaction engine that handles the serial protocol itself.

Software loads the address and the outgoing bytes, then writes the command word. That write launches a transfer. The block emits a one-cycle start pulse toward the engine and shows busy until the engine reports completion. On completion the engine raises a done strobe, together with up to four error causes and, for transfers that read, the incoming bytes. The block records these in a sticky status register that software clears by writing ones. The interrupt output stays high while any status bit is set and its mask bit is on. Software can enable only the done bit, take a single interrupt per transfer, and still read every error cause that came with it.

Top module: `twi_reg_block`

## Requirements
- R1: After reset both clock words read 0x0000301F, configuration reads 0x00003302, and command, target, both data words, status, mask and busy read 0.
- R2: Word offsets are clock-standard 0x00, clock-high-speed 0x04, configuration 0x08, command 0x0C, target 0x10, data-low 0x14, data-high 0x18, status 0x1C, mask 0x20 and busy 0x24. Writable bits are 0xF3FF in each clock word, 0xFFF3 in configuration, 0x0377 in command, 0x03FF in target, all 32 in each data word and 0x1F in mask. Busy ignores writes. Other bits read 0, any other offset reads 0, and an access with hostAddr[1:0] nonzero is dropped and reads 0.
- R3: The engine outputs mirror the registers: engClkStd, engClkHs and engCfg show bits 15:0 of their words, engTarget shows the target word, and engTxData is {data-high, data-low}. The command word decodes with transfer type in bits 9:8 (0 write, 1 read, 2 write-then-read), write count in bits 6:4 and read count in bits 2:0.
- R4: Status bits are sticky. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A completion in the same cycle as a clearing write wins for the bits it sets.
- R5: A command write while not busy updates the command word. engStart is high for exactly the one cycle after the write, and busy reads 1 from that cycle until completion.
- R6: A command write while busy is ignored: the command word keeps its value and no start pulse follows.
- R7: When engDone is high while busy, status bit 0 (done) is set in the same update as bits 1 to 4 from engErr[0..3] (lost arbitration, no response, data collision, bus busy). Busy reads 0 afterward. When engDone is high while not busy, it changes nothing.
- R8: On an accepted completion with transfer type 1 or 2, data-low takes engRxData[31:0] and data-high takes engRxData[63:32]. With type 0 both data words keep their values.
- R9: irq is high exactly when status AND mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | Host access valid this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Byte offset of the access |
| hostWdata | input | 32 | Write data |
| hostRdata | output | 32 | Read data, valid in the same cycle as a read |
| engStart | output | 1 | One-cycle launch pulse to the engine |
| engXferType | output | 2 | Decoded transfer type |
| engWrCount | output | 3 | Write byte count minus one |
| engRdCount | output | 3 | Read byte count minus one |
| engTarget | output | 10 | Target address |
| engTxData | output | 64 | Outgoing data bytes |
| engClkStd | output | 16 | Standard/fast clock setting |
| engClkHs | output | 16 | High-speed clock setting |
| engCfg | output | 16 | Configuration word |
| engDone | input | 1 | Completion strobe from the engine |
| engErr | input | 4 | Error causes, valid with engDone |
| engRxData | input | 64 | Incoming bytes, valid with engDone |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the engine asserts engDone only while a transfer is pending. When done comes while the block is idle, they assume the block discards it. They also assume that the engine's error and data lines only matter in a cycle that carries done. The stimulus drives engDone only at chosen moments, with errors and data attached. It includes one idle done to confirm that an idle done is dropped, and one done that collides with a status-clearing write. The randomized register traffic leaves out the command offset, so that every launch happens in a directed transfer whose completion the bench controls.

// File: rtl/twi_reg_pkg.sv
package twi_reg_pkg;

  localparam int REG_W = 32;

  // word indices; the host offset is index * 4
  localparam int IDX_CLK_STD = 0;
  localparam int IDX_CLK_HS  = 1;
  localparam int IDX_CFG     = 2;
  localparam int IDX_CMD     = 3;
  localparam int IDX_TARGET  = 4;
  localparam int IDX_DAT_LO  = 5;
  localparam int IDX_DAT_HI  = 6;
  localparam int IDX_STS     = 7;
  localparam int IDX_MSK     = 8;
  localparam int IDX_BUSY    = 9;

  localparam int STS_W = 5;
  localparam int ERR_W = 4;

  // writable bit masks per register
  localparam logic [15:0] CLK_MASK = 16'hF3FF;
  localparam logic [15:0] CFG_MASK = 16'hFFF3;
  localparam logic [9:0]  CMD_MASK = 10'h377;

  // one-hot-ish strobes from control to datapath
  typedef struct packed {
    logic wrClkStd;
    logic wrClkHs;
    logic wrCfg;
    logic wrCmd;
    logic wrTarget;
    logic wrDatLo;
    logic wrDatHi;
    logic wrMask;
    logic stsClr;
    logic doneEvt;
    logic loadRx;
    logic rdOk;
  } regStb_t;

endpackage

// File: rtl/twi_reg_ctrl.sv
module twi_reg_ctrl
  import twi_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        cmdType,
  input  logic              engDone,
  output regStb_t           stb,
  output logic              busy,
  output logic              engStart
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             wrEn;
  logic             cmdAccept;
  logic             doneEvt;
  logic             busyQ;
  logic             startQ;

  assign wordIdx = hostAddr[ADDR_W-1:2];
  assign aligned = (hostAddr[1:0] == 2'b00);
  assign wrEn    = hostSel && hostWrite && aligned;

  assign cmdAccept = wrEn && (wordIdx == IDX_W'(IDX_CMD)) && !busyQ;
  assign doneEvt   = engDone && busyQ;

  always_comb begin
    stb          = '0;
    stb.wrClkStd = wrEn && (wordIdx == IDX_W'(IDX_CLK_STD));
    stb.wrClkHs  = wrEn && (wordIdx == IDX_W'(IDX_CLK_HS));
    stb.wrCfg    = wrEn && (wordIdx == IDX_W'(IDX_CFG));
    stb.wrCmd    = cmdAccept;
    stb.wrTarget = wrEn && (wordIdx == IDX_W'(IDX_TARGET));
    stb.wrDatLo  = wrEn && (wordIdx == IDX_W'(IDX_DAT_LO));
    stb.wrDatHi  = wrEn && (wordIdx == IDX_W'(IDX_DAT_HI));
    stb.wrMask   = wrEn && (wordIdx == IDX_W'(IDX_MSK));
    stb.stsClr   = wrEn && (wordIdx == IDX_W'(IDX_STS));
    stb.doneEvt  = doneEvt;
    stb.loadRx   = doneEvt && ((cmdType == 2'd1) || (cmdType == 2'd2));
    stb.rdOk     = hostSel && !hostWrite && aligned;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      startQ <= 1'b0;
    end else begin
      startQ <= cmdAccept;
      if (cmdAccept) busyQ <= 1'b1;
      else if (doneEvt) busyQ <= 1'b0;
    end
  end

  assign busy     = busyQ;
  assign engStart = startQ;

  // R5: a launch pulse only follows an idle cycle and always leaves busy set
  a_r5_start_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> (busyQ && !$past(busyQ)));

  // R5: launch pulse lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  // R7: accepted completion ends the transfer
  a_r7_done_clears_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && engDone) |=> !busyQ);

endmodule

// File: rtl/twi_reg_dp.sv
module twi_reg_dp
  import twi_reg_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [3:0]  FILT_RST   = 4'd3,
  parameter logic [9:0]  DIV_RST    = 10'h01F,
  parameter logic [3:0]  ARBF_RST   = 4'd3,
  parameter logic [3:0]  NACK_RST   = 4'd3,
  parameter logic        ARB_EN_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStb_t           stb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [REG_W-1:0]  hostWdata,
  input  logic              busyIn,
  input  logic [ERR_W-1:0]  engErr,
  input  logic [63:0]       engRxData,
  output logic [REG_W-1:0]  hostRdata,
  output logic [1:0]        cmdType,
  output logic [2:0]        engWrCount,
  output logic [2:0]        engRdCount,
  output logic [9:0]        engTarget,
  output logic [63:0]       engTxData,
  output logic [15:0]       engClkStd,
  output logic [15:0]       engClkHs,
  output logic [15:0]       engCfg,
  output logic              irq
);

  localparam int          IDX_W   = ADDR_W - 2;
  localparam logic [15:0] CLK_RST = {FILT_RST, 2'b00, DIV_RST};
  localparam logic [15:0] CFG_RST = {ARBF_RST, NACK_RST, 1'b0, 3'b000, 2'b00, ARB_EN_RST, 1'b0};

  logic [IDX_W-1:0] wordIdx;
  logic [15:0]      clkQ [2];
  logic [1:0]       clkWr;
  logic [15:0]      cfgQ;
  logic [9:0]       cmdQ;
  logic [9:0]       targetQ;
  logic [31:0]      datQ [2];
  logic [1:0]       datWr;
  logic [STS_W-1:0] stsQ;
  logic [STS_W-1:0] stsD;
  logic [STS_W-1:0] mskQ;

  assign wordIdx = hostAddr[ADDR_W-1:2];
  assign clkWr   = {stb.wrClkHs, stb.wrClkStd};
  assign datWr   = {stb.wrDatHi, stb.wrDatLo};

  // two clock-setting words share one shape
  for (genvar g = 0; g < 2; g++) begin : gClk
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) clkQ[g] <= CLK_RST;
      else if (clkWr[g]) clkQ[g] <= hostWdata[15:0] & CLK_MASK;
    end
  end

  // two data words: completion data wins over a host write
  for (genvar g = 0; g < 2; g++) begin : gDat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) datQ[g] <= '0;
      else if (stb.loadRx) datQ[g] <= engRxData[32*g +: 32];
      else if (datWr[g]) datQ[g] <= hostWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= CFG_RST;
      cmdQ    <= '0;
      targetQ <= '0;
      mskQ    <= '0;
    end else begin
      if (stb.wrCfg)    cfgQ    <= hostWdata[15:0] & CFG_MASK;
      if (stb.wrCmd)    cmdQ    <= hostWdata[9:0] & CMD_MASK;
      if (stb.wrTarget) targetQ <= hostWdata[9:0];
      if (stb.wrMask)   mskQ    <= hostWdata[STS_W-1:0];
    end
  end

  // sticky status: clear by ones, completion sets after the clear
  always_comb begin
    stsD = stsQ;
    if (stb.stsClr)  stsD = stsD & ~hostWdata[STS_W-1:0];
    if (stb.doneEvt) stsD = stsD | {engErr, 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stsQ <= '0;
    else       stsQ <= stsD;
  end

  always_comb begin
    hostRdata = '0;
    if (stb.rdOk) begin
      case (wordIdx)
        IDX_W'(IDX_CLK_STD): hostRdata = {16'h0, clkQ[0]};
        IDX_W'(IDX_CLK_HS):  hostRdata = {16'h0, clkQ[1]};
        IDX_W'(IDX_CFG):     hostRdata = {16'h0, cfgQ};
        IDX_W'(IDX_CMD):     hostRdata = {22'h0, cmdQ};
        IDX_W'(IDX_TARGET):  hostRdata = {22'h0, targetQ};
        IDX_W'(IDX_DAT_LO):  hostRdata = datQ[0];
        IDX_W'(IDX_DAT_HI):  hostRdata = datQ[1];
        IDX_W'(IDX_STS):     hostRdata = {27'h0, stsQ};
        IDX_W'(IDX_MSK):     hostRdata = {27'h0, mskQ};
        IDX_W'(IDX_BUSY):    hostRdata = {31'h0, busyIn};
        default:             hostRdata = '0;
      endcase
    end
  end

  assign cmdType    = cmdQ[9:8];
  assign engWrCount = cmdQ[6:4];
  assign engRdCount = cmdQ[2:0];
  assign engTarget  = targetQ;
  assign engTxData  = {datQ[1], datQ[0]};
  assign engClkStd  = clkQ[0];
  assign engClkHs   = clkQ[1];
  assign engCfg     = cfgQ;
  assign irq        = |(stsQ & mskQ);

  // R4: without a clearing write no status bit falls
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.stsClr) |-> ((stsQ & $past(stsQ)) == $past(stsQ)));

  // R7: an error cause never appears without done beside it
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    (|(stsQ[STS_W-1:1] & ~$past(stsQ[STS_W-1:1]))) |-> stsQ[0]);

  // R6: the command word holds while a transfer is pending
  a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |=> $stable(cmdQ));

  // R8: write-only completions leave the data words alone
  a_r8_no_rx_on_write: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.doneEvt) && ($past(cmdType) == 2'd0) && !$past(stb.wrDatLo)) |-> $stable(datQ[0]));

endmodule

// File: rtl/twi_reg_block.sv
module twi_reg_block
  import twi_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              engStart,
  output logic [1:0]        engXferType,
  output logic [2:0]        engWrCount,
  output logic [2:0]        engRdCount,
  output logic [9:0]        engTarget,
  output logic [63:0]       engTxData,
  output logic [15:0]       engClkStd,
  output logic [15:0]       engClkHs,
  output logic [15:0]       engCfg,
  input  logic              engDone,
  input  logic [3:0]        engErr,
  input  logic [63:0]       engRxData,
  output logic              irq
);

  regStb_t    stb;
  logic       busy;
  logic [1:0] cmdType;

  twi_reg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostSel   (hostSel),
    .hostWrite (hostWrite),
    .hostAddr  (hostAddr),
    .cmdType   (cmdType),
    .engDone   (engDone),
    .stb       (stb),
    .busy      (busy),
    .engStart  (engStart)
  );

  twi_reg_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .busyIn     (busy),
    .engErr     (engErr),
    .engRxData  (engRxData),
    .hostRdata  (hostRdata),
    .cmdType    (cmdType),
    .engWrCount (engWrCount),
    .engRdCount (engRdCount),
    .engTarget  (engTarget),
    .engTxData  (engTxData),
    .engClkStd  (engClkStd),
    .engClkHs   (engClkHs),
    .engCfg     (engCfg),
    .irq        (irq)
  );

  assign engXferType = cmdType;

endmodule

// File: tb/twi_reg_block_bench.sv
module twi_reg_block_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostWrite = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        engStart;
  logic [1:0]  engXferType;
  logic [2:0]  engWrCount;
  logic [2:0]  engRdCount;
  logic [9:0]  engTarget;
  logic [63:0] engTxData;
  logic [15:0] engClkStd;
  logic [15:0] engClkHs;
  logic [15:0] engCfg;
  logic        engDone = 1'b0;
  logic [3:0]  engErr = '0;
  logic [63:0] engRxData = '0;
  logic        irq;

  int nChk = 0;
  int nFail = 0;
  logic [31:0] mdl [16];
  logic        done = 1'b0;

  always #10 clk = ~clk;

  twi_reg_block u_twi_reg_block (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .engStart(engStart), .engXferType(engXferType), .engWrCount(engWrCount),
    .engRdCount(engRdCount), .engTarget(engTarget), .engTxData(engTxData),
    .engClkStd(engClkStd), .engClkHs(engClkHs), .engCfg(engCfg),
    .engDone(engDone), .engErr(engErr), .engRxData(engRxData), .irq(irq)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wrMaskOf(int idx);
    case (idx)
      0, 1: return 32'h0000F3FF;
      2:    return 32'h0000FFF3;
      3:    return 32'h00000377;
      4:    return 32'h000003FF;
      5, 6: return 32'hFFFFFFFF;
      8:    return 32'h0000001F;
      default: return 32'h0;
    endcase
  endfunction

  // expected effect of a host write on the model (idle, no completion)
  function automatic void mdlWrite(int idx, logic [31:0] d);
    if (idx == 7) mdl[7] = mdl[7] & ~(d & 32'h1F);
    else if (idx < 9 && idx != 3) mdl[idx] = d & wrMaskOf(idx);
  endfunction

  task automatic hostWr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWrite = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0; hostWrite = 1'b0;
  endtask

  task automatic hostRd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWrite = 1'b0; hostAddr = a;
    #2;
    d = hostRdata;
    hostSel = 1'b0;
  endtask

  task automatic chkReg(string req, int idx);
    logic [31:0] v;
    hostRd(8'(idx * 4), v);
    chk(req, {32'h0, v}, {32'h0, mdl[idx]});
  endtask

  task automatic chkIrq(string req);
    chk(req, {63'h0, irq}, {63'h0, |(mdl[7][4:0] & mdl[8][4:0])});
  endtask

  // one full transfer through the engine handshake
  task automatic doXfer(logic [1:0] typ, logic [2:0] wl, logic [2:0] rl,
                        logic [3:0] err, logic [63:0] rx);
    logic [31:0] cmdVal;
    logic [31:0] v;
    cmdVal = {22'h0, typ, 1'b0, wl, 1'b0, rl};
    @(negedge clk);
    hostSel = 1'b1; hostWrite = 1'b1; hostAddr = 8'h0C; hostWdata = cmdVal | 32'hFF00_0C88;
    @(negedge clk);
    hostSel = 1'b0; hostWrite = 1'b0;
    chk("R5 start pulse", {63'h0, engStart}, 64'h1);
    chk("R3 decoded command", {58'h0, engXferType, engWrCount, engRdCount}, {58'h0, typ, wl, rl});
    hostRd(8'h24, v);
    chk("R5 busy while pending", {32'h0, v}, 64'h1);
    chk("R5 pulse is one cycle", {63'h0, engStart}, 64'h0);
    // second command while busy must be dropped
    hostWr(8'h0C, ~cmdVal);
    chk("R6 no relaunch", {63'h0, engStart}, 64'h0);
    hostRd(8'h0C, v);
    chk("R6 command kept", {32'h0, v}, {32'h0, cmdVal});
    chk("R6 no relaunch later", {63'h0, engStart}, 64'h0);
    @(negedge clk);
    engDone = 1'b1; engErr = err; engRxData = rx;
    @(negedge clk);
    engDone = 1'b0; engErr = '0; engRxData = '0;
    mdl[7] = mdl[7] | {27'h0, err, 1'b1};
    if (typ == 2'd1 || typ == 2'd2) begin
      mdl[5] = rx[31:0];
      mdl[6] = rx[63:32];
    end
    chkReg("R7 status after done", 7);
    hostRd(8'h24, v);
    chk("R7 busy cleared", {32'h0, v}, 64'h0);
    chkReg("R8 data low after done", 5);
    chkReg("R8 data high after done", 6);
    chkIrq("R9 irq after done");
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) mdl[i] = 32'h0;
    mdl[0] = 32'h301F; mdl[1] = 32'h301F; mdl[2] = 32'h3302;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values, including unused offsets
    for (int i = 0; i < 16; i++) chkReg("R1 reset value", i);
    chk("R1 irq low at reset", {63'h0, irq}, 64'h0);
    chk("R1 no start at reset", {63'h0, engStart}, 64'h0);

    // R2: write masks, read-only busy, unused offsets, misaligned access
    for (int i = 0; i < 16; i++) begin
      if (i != 3 && i != 7) begin
        hostWr(8'(i * 4), 32'hFFFF_FFFF);
        mdlWrite(i, 32'hFFFF_FFFF);
        chkReg("R2 write mask", i);
      end
    end
    hostWr(8'hFC, 32'hFFFF_FFFF);
    hostRd(8'hFC, v);
    chk("R2 far unused offset", {32'h0, v}, 64'h0);
    hostWr(8'h11, 32'h0000_0155);
    chkReg("R2 misaligned write dropped", 4);
    hostRd(8'h15, v);
    chk("R2 misaligned read zero", {32'h0, v}, 64'h0);

    // R9: mask enabled with empty status keeps irq low
    chkIrq("R9 irq low with empty status");

    // R3 plus R2: randomized register traffic against the model
    for (int n = 0; n < 400; n++) begin
      int idx;
      logic [31:0] d;
      idx = int'($urandom_range(0, 13));
      if (idx == 3) idx = 4;
      d = $urandom();
      if ($urandom_range(0, 1) == 1) begin
        hostWr(8'(idx * 4), d);
        mdlWrite(idx, d);
      end else begin
        chkReg("R2 random read", idx);
      end
      if (n % 25 == 0) begin
        chk("R3 std clock out", {48'h0, engClkStd}, {48'h0, mdl[0][15:0]});
        chk("R3 hs clock out", {48'h0, engClkHs}, {48'h0, mdl[1][15:0]});
        chk("R3 cfg out", {48'h0, engCfg}, {48'h0, mdl[2][15:0]});
        chk("R3 target out", {54'h0, engTarget}, {54'h0, mdl[4][9:0]});
        chk("R3 tx data out", engTxData, {mdl[6], mdl[5]});
        chkIrq("R9 irq random");
      end
    end

    // directed transfers, mask only done
    hostWr(8'h20, 32'h1);
    mdl[8] = 32'h1;
    hostWr(8'h14, 32'hA5A5_0001);
    hostWr(8'h18, 32'h5A5A_0002);
    mdlWrite(5, 32'hA5A5_0001);
    mdlWrite(6, 32'h5A5A_0002);
    doXfer(2'd0, 3'd3, 3'd0, 4'b0000, 64'hDEAD_BEEF_0BAD_F00D);  // R8 write keeps data
    hostRd(8'h1C, v);
    hostWr(8'h1C, v);
    mdl[7] = 32'h0;
    chkReg("R4 write-back clears status", 7);
    chkIrq("R9 irq low after clear");

    doXfer(2'd1, 3'd0, 3'd7, 4'b1010, 64'h0123_4567_89AB_CDEF);
    // R4: writing zeros leaves status alone, partial clear hits only ones
    hostWr(8'h1C, 32'h0);
    chkReg("R4 zero write keeps status", 7);
    hostWr(8'h1C, 32'h4);
    mdl[7] = mdl[7] & ~32'h4;
    chkReg("R4 partial clear", 7);
    chkIrq("R9 done still unmasked");

    // R7: done while idle is dropped
    @(negedge clk);
    engDone = 1'b1; engErr = 4'b1111; engRxData = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    engDone = 1'b0; engErr = '0; engRxData = '0;
    chkReg("R7 idle done ignored status", 7);
    chkReg("R7 idle done ignored data", 5);

    // R4: completion in the same cycle as a clearing write
    hostWr(8'h1C, 32'h1F);
    mdl[7] = 32'h0;
    hostWr(8'h1C, 32'h0);
    doXfer(2'd2, 3'd1, 3'd1, 4'b0100, 64'h1111_2222_3333_4444);
    hostWr(8'h0C, 32'h0000_0200);
    @(negedge clk);
    hostSel = 1'b1; hostWrite = 1'b1; hostAddr = 8'h1C; hostWdata = 32'h1F;
    engDone = 1'b1; engErr = 4'b0001; engRxData = 64'h7777_8888_9999_AAAA;
    @(negedge clk);
    hostSel = 1'b0; hostWrite = 1'b0; engDone = 1'b0; engErr = '0;
    mdl[7] = 32'h3;
    mdl[5] = 32'h9999_AAAA; mdl[6] = 32'h7777_8888;
    chkReg("R4 set wins over clear", 7);
    chkReg("R8 rx low on write-read", 5);
    chkReg("R8 rx high on write-read", 6);

    // randomized transfers
    for (int n = 0; n < 40; n++) begin
      logic [1:0] typ;
      logic [63:0] rx;
      typ = 2'($urandom_range(0, 2));
      rx = {$urandom(), $urandom()};
      hostWr(8'h20, 32'($urandom_range(0, 31)));
      mdl[8] = hostWdata & 32'h1F;
      doXfer(typ, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
             4'($urandom_range(0, 15)), rx);
      if ($urandom_range(0, 1) == 1) begin
        hostRd(8'h1C, v);
        hostWr(8'h1C, v);
        mdl[7] = 32'h0;
        chkIrq("R9 irq after clear");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule